// File: doc/BRIEF.md
# Line-Scan Sensor Timing Generator

This block drives the timing pins of a linear image sensor (charge-coupled or contact type) and two control lines for the analog front end that conditions the sensor's video. A free-running line counter covers a programmable number of clocks per line. One line-start pulse is placed at a programmable offset with a programmable width. Once that pulse ends, a run of pixel periods follows, each a programmable number of clocks long, up to a programmable pixel count. Two pixel-rate clocks repeat inside every pixel period. Each has its own delay into the period and its own high time, and one of them is driven active low.

Each of the two video control lines has a mode bit. The mode selects whether its active window is placed in line-clock coordinates or in pixel-phase coordinates, and a polarity bit inverts it. All settings sit on plain input ports. The block samples them into a shadow copy when a line begins, so a setting changed mid-line never produces a partly reconfigured line. Holding the line enable high gives back-to-back lines. Dropping it lets the current line finish and then parks every output in its idle level.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset, and whenever no line is running, `sens_start` is low, `sens_clk1n` is high, `sens_clk2` is low, and each `vid_ctl[i]` equals the polarity bit `i` captured at the most recent line start (0 after reset).
- R2: When `line_en` is seen high at a clock edge while idle, the next cycle is line clock 0. Line clocks count 0 to `cfg_line_len`-1. While `line_en` stays high, each new line starts directly after the previous one.
- R3: `sens_start` is high exactly on line clocks `cfg_start_ofs` through `cfg_start_ofs`+`cfg_start_wid`-1 of every line.
- R4: The pixel region begins at line clock `cfg_start_ofs`+`cfg_start_wid`. Pixel p (counting from 0) takes `cfg_pix_per` clocks with phases 0 to `cfg_pix_per`-1. Only pixels with p < `cfg_pix_num` are active. No pixel clock is produced outside active pixels.
- R5: `sens_clk2` is high on the phases `cfg_c2_dly` through `cfg_c2_dly`+`cfg_c2_wid`-1 of every active pixel, and low otherwise.
- R6: `sens_clk1n` is low on the phases `cfg_c1_dly` through `cfg_c1_dly`+`cfg_c1_wid`-1 of every active pixel, and high otherwise.
- R7: With `cfg_vc_mode[i]`=0 (line mode), the window of `vid_ctl[i]` covers line clocks b through b+w-1. Here b is `cfg_vc_beg[i*12 +: 12]` and w is `cfg_vc_wid[i*12 +: 12]`.
- R8: With `cfg_vc_mode[i]`=1 (pixel mode), the window of `vid_ctl[i]` covers phases b through b+w-1 of every active pixel.
- R9: With `cfg_vc_pol[i]`=1, `vid_ctl[i]` is the inverse of its window. With 0, it equals the window.
- R10: Every `cfg_*` input is sampled only at the edge that starts a line. Changes made during a line take effect from the next line.
- R11: If `line_en` is low at the edge that ends a line, that line still completes and the block goes idle. Taking `line_en` low in mid-line does not cut the line short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | Keep generating lines while high |
| cfg_line_len | input | 12 | Clocks per line |
| cfg_start_ofs | input | 12 | Line clock at which the start pulse begins |
| cfg_start_wid | input | 12 | Start pulse width in clocks |
| cfg_pix_per | input | 8 | Clocks per pixel period |
| cfg_pix_num | input | 12 | Active pixels per line |
| cfg_c1_dly | input | 8 | Phase at which the active-low pixel clock asserts |
| cfg_c1_wid | input | 8 | Active time of the active-low pixel clock |
| cfg_c2_dly | input | 8 | Phase at which the second pixel clock rises |
| cfg_c2_wid | input | 8 | High time of the second pixel clock |
| cfg_vc_mode | input | 2 | Per video line: 0 line mode, 1 pixel mode |
| cfg_vc_pol | input | 2 | Per video line: 1 inverts the output |
| cfg_vc_beg | input | 24 | Window begin, 12 bits per video line |
| cfg_vc_wid | input | 24 | Window width, 12 bits per video line |
| sens_start | output | 1 | Line start pulse |
| sens_clk1n | output | 1 | Active-low pixel clock |
| sens_clk2 | output | 1 | Active-high pixel clock |
| vid_ctl | output | 2 | Video front-end control lines |

## Verification
The assertions take for granted that a line is at least two clocks long and that the pixel period is at least one clock. Under those conditions the line counter advances by one on every non-final clock, and the shadowed settings stay frozen inside a line. The assertions also rely on the start pulse and the pixel region being separated by the shadowed start offset plus width, which holds for any setting values. Every stimulus keeps the line length and pixel period inside those bounds. The tests rewrite the setting ports only at a falling clock edge, including during a line, which is how the frozen-shadow behaviour is exercised.

// File: rtl/scan_tg_pkg.sv
package scan_tg_pkg;

    // Coordinate system in which a video control window is placed
    typedef enum logic {
        VC_LINE  = 1'b0,
        VC_PIXEL = 1'b1
    } vc_mode_e;

    localparam int unsigned DEF_LINE_W = 12;
    localparam int unsigned DEF_PHASE_W = 8;
    localparam int unsigned DEF_COUNT_W = 12;

endpackage

// File: rtl/scan_tg_win.sv
// Window comparator: hit while pos lies in [beg, beg+wid) and en is set.
module scan_tg_win #(
    parameter int unsigned W = 12
) (
    input  logic         en,
    input  logic [W-1:0] pos,
    input  logic [W-1:0] beg,
    input  logic [W-1:0] wid,
    output logic         hit
);
    logic [W:0] lim;

    always_comb begin
        lim = {1'b0, beg} + {1'b0, wid};
        hit = en && (pos >= beg) && ({1'b0, pos} < lim);
    end
endmodule

// File: rtl/scan_tg_seq.sv
// Line/pixel sequencer: line counter, pixel phase and index, and the
// configuration shadow that is reloaded only at a line boundary.
module scan_tg_seq #(
    parameter int unsigned LW = 12,
    parameter int unsigned PW = 8,
    parameter int unsigned NW = 12,
    parameter int unsigned CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_en,
    input  logic [CW-1:0] cfg_in,
    input  logic [LW-1:0] len_sh,
    input  logic [LW:0]   st_end,
    input  logic [PW-1:0] per_sh,
    input  logic [NW-1:0] num_sh,
    output logic          run,
    output logic [LW-1:0] lc,
    output logic [PW-1:0] pp,
    output logic          pix_act,
    output logic [CW-1:0] cfg_sh
);
    localparam logic [LW-1:0] LC_ONE = {{(LW-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] PP_ONE = {{(PW-1){1'b0}}, 1'b1};
    localparam logic [NW-1:0] PI_ONE = {{(NW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          run;
        logic [LW-1:0] lc;
        logic [PW-1:0] pp;
        logic [NW-1:0] pi;
        logic [CW-1:0] sh;
    } seq_t;

    seq_t s_d, s_q;
    logic last, pp_wrap;

    always_comb begin
        last    = ({1'b0, s_q.lc} + {1'b0, LC_ONE}) >= {1'b0, len_sh};
        pix_act = s_q.run && ({1'b0, s_q.lc} >= st_end) && (s_q.pi < num_sh);
        pp_wrap = ({1'b0, s_q.pp} + {1'b0, PP_ONE}) >= {1'b0, per_sh};
        s_d     = s_q;
        if (!s_q.run || last) begin
            s_d.lc = '0;
            s_d.pp = '0;
            s_d.pi = '0;
            if (line_en) begin
                s_d.run = 1'b1;
                s_d.sh  = cfg_in;
            end else begin
                s_d.run = 1'b0;
            end
        end else begin
            s_d.lc = s_q.lc + LC_ONE;
            if (pix_act) begin
                if (pp_wrap) begin
                    s_d.pp = '0;
                    s_d.pi = s_q.pi + PI_ONE;
                end else begin
                    s_d.pp = s_q.pp + PP_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run    = s_q.run;
    assign lc     = s_q.lc;
    assign pp     = s_q.pp;
    assign cfg_sh = s_q.sh;

    // R2: inside a line the counter steps by exactly one clock
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !last) |=> (s_q.run && s_q.lc == $past(s_q.lc) + LC_ONE));

    // R10: shadowed settings are frozen until the line ends
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !last) |=> $stable(s_q.sh));

    // R11: a line ending with the enable low leaves the block idle
    p_stop_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && last && !line_en) |=> !s_q.run);

    // R2: a line ending with the enable high restarts at clock 0
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && last && line_en) |=> (s_q.run && s_q.lc == '0));
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_tg_pkg::*;
#(
    parameter int unsigned LW = DEF_LINE_W,
    parameter int unsigned PW = DEF_PHASE_W,
    parameter int unsigned NW = DEF_COUNT_W,
    parameter int unsigned NVC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_en,
    input  logic [LW-1:0]     cfg_line_len,
    input  logic [LW-1:0]     cfg_start_ofs,
    input  logic [LW-1:0]     cfg_start_wid,
    input  logic [PW-1:0]     cfg_pix_per,
    input  logic [NW-1:0]     cfg_pix_num,
    input  logic [PW-1:0]     cfg_c1_dly,
    input  logic [PW-1:0]     cfg_c1_wid,
    input  logic [PW-1:0]     cfg_c2_dly,
    input  logic [PW-1:0]     cfg_c2_wid,
    input  logic [NVC-1:0]    cfg_vc_mode,
    input  logic [NVC-1:0]    cfg_vc_pol,
    input  logic [NVC*LW-1:0] cfg_vc_beg,
    input  logic [NVC*LW-1:0] cfg_vc_wid,
    output logic              sens_start,
    output logic              sens_clk1n,
    output logic              sens_clk2,
    output logic [NVC-1:0]    vid_ctl
);
    // Offsets of each field inside the shadowed configuration vector
    localparam int unsigned O_LL  = 0;
    localparam int unsigned O_SO  = O_LL + LW;
    localparam int unsigned O_SW  = O_SO + LW;
    localparam int unsigned O_PP  = O_SW + LW;
    localparam int unsigned O_PN  = O_PP + PW;
    localparam int unsigned O_C1D = O_PN + NW;
    localparam int unsigned O_C1W = O_C1D + PW;
    localparam int unsigned O_C2D = O_C1W + PW;
    localparam int unsigned O_C2W = O_C2D + PW;
    localparam int unsigned O_MD  = O_C2W + PW;
    localparam int unsigned O_PL  = O_MD + NVC;
    localparam int unsigned O_VB  = O_PL + NVC;
    localparam int unsigned O_VW  = O_VB + NVC*LW;
    localparam int unsigned CW    = O_VW + NVC*LW;

    logic [CW-1:0] cfg_vec, sh;
    logic          run_w, pix_act_w;
    logic [LW-1:0] lc_w;
    logic [PW-1:0] pp_w;
    logic [LW:0]   st_end;
    logic          c1_hit;

    assign cfg_vec = {cfg_vc_wid, cfg_vc_beg, cfg_vc_pol, cfg_vc_mode,
                      cfg_c2_wid, cfg_c2_dly, cfg_c1_wid, cfg_c1_dly,
                      cfg_pix_num, cfg_pix_per, cfg_start_wid,
                      cfg_start_ofs, cfg_line_len};

    assign st_end = {1'b0, sh[O_SO +: LW]} + {1'b0, sh[O_SW +: LW]};

    scan_tg_seq #(.LW(LW), .PW(PW), .NW(NW), .CW(CW)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_en (line_en),
        .cfg_in  (cfg_vec),
        .len_sh  (sh[O_LL +: LW]),
        .st_end  (st_end),
        .per_sh  (sh[O_PP +: PW]),
        .num_sh  (sh[O_PN +: NW]),
        .run     (run_w),
        .lc      (lc_w),
        .pp      (pp_w),
        .pix_act (pix_act_w),
        .cfg_sh  (sh)
    );

    scan_tg_win #(.W(LW)) start_win_i (
        .en  (run_w),
        .pos (lc_w),
        .beg (sh[O_SO +: LW]),
        .wid (sh[O_SW +: LW]),
        .hit (sens_start)
    );

    scan_tg_win #(.W(PW)) c1_win_i (
        .en  (pix_act_w),
        .pos (pp_w),
        .beg (sh[O_C1D +: PW]),
        .wid (sh[O_C1W +: PW]),
        .hit (c1_hit)
    );
    assign sens_clk1n = ~c1_hit;

    scan_tg_win #(.W(PW)) c2_win_i (
        .en  (pix_act_w),
        .pos (pp_w),
        .beg (sh[O_C2D +: PW]),
        .wid (sh[O_C2W +: PW]),
        .hit (sens_clk2)
    );

    for (genvar gi = 0; gi < NVC; gi++) begin : g_vc
        logic          px_mode;
        logic [LW-1:0] pos;
        logic          en;
        logic          hit;

        assign px_mode = (vc_mode_e'(sh[O_MD + gi]) == VC_PIXEL);
        assign pos     = px_mode ? LW'(pp_w) : lc_w;
        assign en      = px_mode ? pix_act_w : run_w;

        scan_tg_win #(.W(LW)) vc_win_i (
            .en  (en),
            .pos (pos),
            .beg (sh[O_VB + gi*LW +: LW]),
            .wid (sh[O_VW + gi*LW +: LW]),
            .hit (hit)
        );

        assign vid_ctl[gi] = hit ^ sh[O_PL + gi];

        // R9: an idle channel rests at its shadowed polarity
        p_vc_idle_pol_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !run_w |-> (vid_ctl[gi] == sh[O_PL + gi]));
    end

    // R1: sensor pins are parked whenever no line runs
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |-> (!sens_start && sens_clk1n && !sens_clk2));

    // R5, R6: no pixel clock outside an active pixel
    p_clk_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_act_w |-> (!sens_clk2 && sens_clk1n));

    // R4: the pixel region never overlaps the start pulse
    p_start_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sens_start |-> !pix_act_w);
endmodule

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb_top;
    localparam int LW = 12;
    localparam int PW = 8;
    localparam int NW = 12;

    typedef struct packed {
        int ll; int so; int sw; int pp; int pn;
        int d1; int w1; int d2; int w2;
        logic [1:0] md; logic [1:0] pol;
        int vb0; int vb1; int vw0; int vw1;
    } cfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_en = 1'b0;
    logic [LW-1:0] cfg_line_len = '0, cfg_start_ofs = '0, cfg_start_wid = '0;
    logic [PW-1:0] cfg_pix_per = '0;
    logic [NW-1:0] cfg_pix_num = '0;
    logic [PW-1:0] cfg_c1_dly = '0, cfg_c1_wid = '0, cfg_c2_dly = '0, cfg_c2_wid = '0;
    logic [1:0] cfg_vc_mode = '0, cfg_vc_pol = '0;
    logic [2*LW-1:0] cfg_vc_beg = '0, cfg_vc_wid = '0;
    logic sens_start, sens_clk1n, sens_clk2;
    logic [1:0] vid_ctl;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    scan_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .line_en(line_en),
        .cfg_line_len(cfg_line_len), .cfg_start_ofs(cfg_start_ofs),
        .cfg_start_wid(cfg_start_wid), .cfg_pix_per(cfg_pix_per),
        .cfg_pix_num(cfg_pix_num), .cfg_c1_dly(cfg_c1_dly),
        .cfg_c1_wid(cfg_c1_wid), .cfg_c2_dly(cfg_c2_dly),
        .cfg_c2_wid(cfg_c2_wid), .cfg_vc_mode(cfg_vc_mode),
        .cfg_vc_pol(cfg_vc_pol), .cfg_vc_beg(cfg_vc_beg),
        .cfg_vc_wid(cfg_vc_wid), .sens_start(sens_start),
        .sens_clk1n(sens_clk1n), .sens_clk2(sens_clk2), .vid_ctl(vid_ctl)
    );

    task automatic chk(logic act, logic exp, string msg);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", msg, act, exp);
        end
    endtask

    task automatic apply_cfg(cfg_t c);
        cfg_line_len  = LW'(c.ll);
        cfg_start_ofs = LW'(c.so);
        cfg_start_wid = LW'(c.sw);
        cfg_pix_per   = PW'(c.pp);
        cfg_pix_num   = NW'(c.pn);
        cfg_c1_dly    = PW'(c.d1);
        cfg_c1_wid    = PW'(c.w1);
        cfg_c2_dly    = PW'(c.d2);
        cfg_c2_wid    = PW'(c.w2);
        cfg_vc_mode   = c.md;
        cfg_vc_pol    = c.pol;
        cfg_vc_beg    = {LW'(c.vb1), LW'(c.vb0)};
        cfg_vc_wid    = {LW'(c.vw1), LW'(c.vw0)};
    endtask

    // Expected outputs on line clock k, computed from the requirements
    task automatic compare_at(int k, cfg_t c, string tag);
        int  se, ph, idx, b, w;
        bit  act, win;
        se  = c.so + c.sw;
        act = (k >= se) && (((k - se) / c.pp) < c.pn);
        ph  = (k >= se) ? (k - se) % c.pp : 0;
        chk(sens_start, (k >= c.so) && (k < se), $sformatf("%s R3 start k=%0d", tag, k));
        chk(sens_clk2, act && ph >= c.d2 && ph < c.d2 + c.w2,
            $sformatf("%s R5 R4 clk2 k=%0d", tag, k));
        chk(sens_clk1n, !(act && ph >= c.d1 && ph < c.d1 + c.w1),
            $sformatf("%s R6 clk1n k=%0d", tag, k));
        for (int i = 0; i < 2; i++) begin
            b = (i == 0) ? c.vb0 : c.vb1;
            w = (i == 0) ? c.vw0 : c.vw1;
            if (c.md[i]) win = act && ph >= b && ph < b + w;
            else         win = (k >= b) && (k < b + w);
            chk(vid_ctl[i], win ^ c.pol[i],
                $sformatf("%s %s %s vid%0d k=%0d", tag, c.md[i] ? "R8" : "R7",
                          c.pol[i] ? "R9" : "", i, k));
        end
    endtask

    // Check one line; at clock chg_at drive nxt and set the enable to en_after
    task automatic check_line(cfg_t c, cfg_t nxt, int chg_at, bit en_after, string tag);
        for (int k = 0; k < c.ll; k++) begin
            @(negedge clk);
            compare_at(k, c, tag);
            if (k == chg_at) begin
                apply_cfg(nxt);
                line_en = en_after;
            end
        end
    endtask

    task automatic check_idle(logic [1:0] pol, string tag, int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(sens_start, 1'b0, {tag, " R1 idle start"});
            chk(sens_clk1n, 1'b1, {tag, " R1 idle clk1n"});
            chk(sens_clk2, 1'b0, {tag, " R1 idle clk2"});
            chk(vid_ctl[0], pol[0], {tag, " R1 R9 idle vid0"});
            chk(vid_ctl[1], pol[1], {tag, " R1 R9 idle vid1"});
        end
    endtask

    cfg_t ca = '{ll:40, so:2, sw:3, pp:6, pn:5, d1:1, w1:2, d2:3, w2:2,
                 md:2'b00, pol:2'b00, vb0:0, vb1:10, vw0:4, vw1:20};
    cfg_t cp = '{ll:20, so:0, sw:1, pp:4, pn:3, d1:0, w1:2, d2:2, w2:2,
                 md:2'b11, pol:2'b10, vb0:0, vb1:2, vw0:3, vw1:1};
    cfg_t cb = '{ll:24, so:4, sw:2, pp:3, pn:4, d1:0, w1:1, d2:1, w2:1,
                 md:2'b01, pol:2'b01, vb0:1, vb1:6, vw0:2, vw1:5};
    cfg_t cc = '{ll:30, so:1, sw:2, pp:5, pn:2, d1:2, w1:3, d2:0, w2:4,
                 md:2'b10, pol:2'b00, vb0:3, vb1:0, vw0:2, vw1:30};

    task automatic t_reset();
        check_idle(2'b00, "reset", 1);
        @(negedge clk);
        rst_n = 1'b1;
        apply_cfg(ca);
        check_idle(2'b00, "after reset R1", 3);
    endtask

    task automatic t_line_mode();
        apply_cfg(ca);
        line_en = 1'b1;
        check_line(ca, ca, ca.ll - 1, 1'b1, "R2 line1");
        check_line(ca, ca, ca.ll - 1, 1'b0, "R2 line2");
        check_idle(ca.pol, "R11 after line mode", 3);
    endtask

    task automatic t_pixel_mode();
        apply_cfg(cp);
        line_en = 1'b1;
        check_line(cp, cp, cp.ll - 1, 1'b1, "R8 line1");
        check_line(cp, cp, cp.ll - 1, 1'b0, "R8 line2");
        check_idle(cp.pol, "R9 after pixel mode", 3);
    endtask

    task automatic t_update();
        apply_cfg(ca);
        line_en = 1'b1;
        check_line(ca, cb, 5, 1'b1, "R10 old line");
        check_line(cb, cb, cb.ll - 1, 1'b0, "R10 new line");
        check_idle(cb.pol, "R10 after update", 3);
    endtask

    task automatic t_stop_mid();
        apply_cfg(cc);
        line_en = 1'b1;
        check_line(cc, cc, 2, 1'b0, "R11 R4 early drop");
        check_idle(cc.pol, "R11 stopped", 4);
    endtask

    initial begin
        t_reset();
        t_line_mode();
        t_pixel_mode();
        t_update();
        t_stop_mid();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule